// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin Controller

This block drives a single open-drain style status pin from the activity signals of a flash write state machine (WSM). The pin is either pulled low or released to high impedance. A configuration strobe selects how the pin reports activity. After reset the pin reports a plain ready/busy level: it is pulled low while an operation runs and released when the machine is idle or suspended.

The other three modes turn the pin into a completion interrupt. The pin stays released while operations run. When a selected kind of operation finishes, it pulses low for a fixed number of clock cycles. Because one mode reacts only to program completions, the host can leave a long erase running in the background without the pin ever reporting it. The host can therefore wait on a hardware edge instead of polling a status register.

Command decoding and pad electrical behaviour are handled elsewhere. The block receives an already decoded configuration strobe and returns two pad controls.

Top module: `stsp_status_pin`

## Requirements
- R1: After reset the block is in level mode (code 0) and the pin is released: `sts_drive_low`=0, `sts_hiz`=1.
- R2: In level mode the pin is driven low in the cycle after `wsm_busy`=1 is sampled with `wsm_suspended`=0, for every operation code: 0 block erase, 1 chip erase, 2 program, 3 lock-bit configuration.
- R3: In level mode the pin is released in the cycle after `wsm_busy`=0 is sampled.
- R4: In level mode the pin is released in the cycle after `wsm_suspended`=1 is sampled, even while `wsm_busy`=1. It is driven low again after `wsm_suspended` returns to 0.
- R5: A `cfg_wr` pulse latches `cfg_mode`. The codes are 0 level, 1 erase-done pulse, 2 program-done pulse, 3 any-done pulse. The new mode applies from the next cycle, and the write cancels any completion pulse in progress.
- R6: A completion is a cycle in which `wsm_busy` falls. In a pulse mode, a selected completion drives the pin low for exactly PULSE_CYC cycles, starting in the cycle after the fall is sampled.
- R7: In mode 1, completions of operation codes 0 and 1 produce a pulse. A program completion produces none, and the pin stays released while any operation is busy.
- R8: In mode 2, a program completion (code 2) produces a pulse, and erase completions are masked.
- R9: In mode 3, erase and program completions both produce a pulse. A lock-bit configuration completion (code 3) never produces a pulse in any mode.
- R10: A selected completion that arrives while a pulse is running restarts the full PULSE_CYC count.
- R11: `sts_hiz` is always the complement of `sts_drive_low`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wsm_busy | input | 1 | WSM is running an operation |
| wsm_op | input | 2 | Operation code, held stable while busy |
| wsm_suspended | input | 1 | Running operation is suspended |
| cfg_wr | input | 1 | One-cycle strobe that loads a new mode |
| cfg_mode | input | 2 | Mode code loaded by `cfg_wr` |
| sts_drive_low | output | 1 | Enable for the pad pull-down |
| sts_hiz | output | 1 | Pad is released to high impedance |

## Verification
A wrong mode register shows at the pin in the first cycle of the next operation or completion. The pin then either follows busy where it should pulse, or pulses where it should follow busy. A corrupted pulse counter shows as a pulse that is too long or too short, and this is visible within PULSE_CYC+1 cycles of the busy fall. A fault in the latched operation code shows as a missing or spurious pulse on the first masked or selected completion, one cycle after busy falls.

// File: rtl/stsp_pkg.sv
// Package: shared encodings for the status pin controller.
// Assumes the WSM operation code is two bits wide.
package stsp_pkg;

    typedef enum logic [1:0] {
        STS_LEVEL      = 2'd0,
        STS_ERASE_DONE = 2'd1,
        STS_PROG_DONE  = 2'd2,
        STS_ANY_DONE   = 2'd3
    } sts_mode_e;

    typedef enum logic [1:0] {
        OP_BLK_ERASE  = 2'd0,
        OP_CHIP_ERASE = 2'd1,
        OP_PROGRAM    = 2'd2,
        OP_LOCK_CFG   = 2'd3
    } wsm_op_e;

    // True for either erase flavour
    function automatic logic op_is_erase(input wsm_op_e op);
        return (op == OP_BLK_ERASE) || (op == OP_CHIP_ERASE);
    endfunction

endpackage

// File: rtl/stsp_mode_reg.sv
// Module: holds the pin reporting mode.
// Assumes cfg_wr is a single-cycle strobe from the command decoder.
module stsp_mode_reg
    import stsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_wr,
    input  logic [1:0] cfg_mode,
    output sts_mode_e mode_q
);

    // Load a new mode on the strobe; reset selects level reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= STS_LEVEL;
        end else if (cfg_wr) begin
            mode_q <= sts_mode_e'(cfg_mode);
        end
    end

endmodule

// File: rtl/stsp_done_detect.sv
// Module: registers WSM activity and flags completions by kind.
// Assumes wsm_op is stable while wsm_busy is high.
module stsp_done_detect
    import stsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wsm_busy,
    input  logic [1:0] wsm_op,
    input  logic       wsm_suspended,
    output logic       busy_q,
    output logic       susp_q,
    output wsm_op_e    op_q,
    output logic       erase_done,
    output logic       prog_done
);

    logic done;

    // Capture busy, suspend and the running operation code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            susp_q <= 1'b0;
            op_q   <= OP_BLK_ERASE;
        end else begin
            busy_q <= wsm_busy;
            susp_q <= wsm_suspended;
            if (wsm_busy) begin
                op_q <= wsm_op_e'(wsm_op);
            end
        end
    end

    // A falling busy marks the end of the latched operation
    always_comb begin
        done       = busy_q && !wsm_busy;
        erase_done = done && op_is_erase(op_q);
        prog_done  = done && (op_q == OP_PROGRAM);
    end

endmodule

// File: rtl/stsp_pulse_timer.sv
// Module: down-counter that holds a pulse active for PULSE_CYC cycles.
// Assumes PULSE_CYC >= 1; clear has priority over trigger.
module stsp_pulse_timer #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic trigger,
    output logic active
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt;

    // Reload on trigger, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (trigger) begin
            cnt <= CW'(PULSE_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Pulse is live while the count is non-zero
    always_comb active = (cnt != '0);

endmodule

// File: rtl/stsp_status_pin.sv
// Module: top of the configurable ready/busy status pin.
// Level mode follows WSM activity; pulse modes flag selected completions.
// Assumes the pad inverts nothing: drive_low enables the pull-down.
module stsp_status_pin
    import stsp_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wsm_busy,
    input  logic [1:0] wsm_op,
    input  logic       wsm_suspended,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    output logic       sts_drive_low,
    output logic       sts_hiz
);

    sts_mode_e mode_q;
    wsm_op_e   op_q;
    logic      busy_q;
    logic      susp_q;
    logic      erase_done;
    logic      prog_done;
    logic      trigger;
    logic      pulse_active;

    stsp_mode_reg i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_mode (cfg_mode),
        .mode_q   (mode_q)
    );

    stsp_done_detect i_det (
        .clk           (clk),
        .rst_n         (rst_n),
        .wsm_busy      (wsm_busy),
        .wsm_op        (wsm_op),
        .wsm_suspended (wsm_suspended),
        .busy_q        (busy_q),
        .susp_q        (susp_q),
        .op_q          (op_q),
        .erase_done    (erase_done),
        .prog_done     (prog_done)
    );

    // Pick which completions the current mode reports
    always_comb begin
        unique case (mode_q)
            STS_ERASE_DONE: trigger = erase_done;
            STS_PROG_DONE:  trigger = prog_done;
            STS_ANY_DONE:   trigger = erase_done || prog_done;
            default:        trigger = 1'b0;
        endcase
    end

    stsp_pulse_timer #(
        .PULSE_CYC (PULSE_CYC)
    ) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cfg_wr),
        .trigger (trigger),
        .active  (pulse_active)
    );

    // Drive the pad from level activity or from the pulse timer
    always_comb begin
        if (mode_q == STS_LEVEL) begin
            sts_drive_low = busy_q && !susp_q;
        end else begin
            sts_drive_low = pulse_active;
        end
        sts_hiz = !sts_drive_low;
    end

endmodule

// File: rtl/stsp_status_pin_chk.sv
// Module: property checker for the status pin, bound to the top.
// Assumes it observes the top's ports plus its mode, busy and op registers.
module stsp_status_pin_chk
    import stsp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      wsm_busy,
    input logic      wsm_suspended,
    input logic      cfg_wr,
    input logic [1:0] cfg_mode,
    input logic      sts_drive_low,
    input logic      sts_hiz,
    input sts_mode_e mode_q,
    input logic      busy_q,
    input wsm_op_e   op_q
);

    // R1: pin is released in the first cycle out of reset
    p_reset_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sts_hiz && !sts_drive_low));

    // R2: level mode pulls low after busy without suspend
    p_level_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == STS_LEVEL && $past(rst_n) && $past(wsm_busy) && !$past(wsm_suspended))
        |-> sts_drive_low);

    // R3: level mode releases after idle
    p_level_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == STS_LEVEL && !$past(wsm_busy)) |-> !sts_drive_low);

    // R4: level mode releases while suspended
    p_level_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == STS_LEVEL && $past(wsm_suspended)) |-> !sts_drive_low);

    // R5: a write selecting a pulse mode leaves the pin released
    p_cfg_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_wr) && $past(cfg_mode) != 2'd0) |-> !sts_drive_low);

    // R6: a pulse starts only right after busy falls
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != STS_LEVEL && $past(mode_q) == mode_q && $rose(sts_drive_low))
        |-> ($past(busy_q) && !$past(wsm_busy)));

    // R9: lock-bit configuration completions never start a pulse
    p_lock_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != STS_LEVEL && $past(mode_q) == mode_q && $rose(sts_drive_low))
        |-> ($past(op_q) != OP_LOCK_CFG));

endmodule

bind stsp_status_pin stsp_status_pin_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wsm_busy      (wsm_busy),
    .wsm_suspended (wsm_suspended),
    .cfg_wr        (cfg_wr),
    .cfg_mode      (cfg_mode),
    .sts_drive_low (sts_drive_low),
    .sts_hiz       (sts_hiz),
    .mode_q        (mode_q),
    .busy_q        (busy_q),
    .op_q          (op_q)
);

// File: tb/test_stsp_status_pin.sv
`timescale 1ns/1ps
module test_stsp_status_pin;

    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wsm_busy = 1'b0;
    logic [1:0] wsm_op = 2'd0;
    logic       wsm_suspended = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       sts_drive_low;
    logic       sts_hiz;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stsp_status_pin #(.PULSE_CYC(P)) i_stsp_status_pin (
        .clk           (clk),
        .rst_n         (rst_n),
        .wsm_busy      (wsm_busy),
        .wsm_op        (wsm_op),
        .wsm_suspended (wsm_suspended),
        .cfg_wr        (cfg_wr),
        .cfg_mode      (cfg_mode),
        .sts_drive_low (sts_drive_low),
        .sts_hiz       (sts_hiz)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_mode = m;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Busy for n cycles, then drop busy; returns at the negedge busy falls
    task automatic run_op(input logic [1:0] op, input int n);
        @(negedge clk);
        wsm_op = op;
        wsm_busy = 1'b1;
        repeat (n) @(negedge clk);
        wsm_busy = 1'b0;
    endtask

    // Count consecutive low cycles from the next negedge
    task automatic measure(output int len);
        len = 0;
        @(negedge clk);
        while (sts_drive_low && len < 20) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 drive_low after reset", sts_drive_low, 0);
        check("R1 hiz after reset", sts_hiz, 1);
        run_op(2'd2, 2);   // still level mode: follows busy
        check("R1 default level mode", sts_drive_low, 1);
        @(negedge clk);
    endtask

    task automatic t_level();
        for (int op = 0; op < 4; op++) begin
            @(negedge clk);
            wsm_op = op[1:0];
            wsm_busy = 1'b1;
            @(negedge clk);
            check($sformatf("R2 level low op%0d", op), sts_drive_low, 1);
            check("R11 hiz complement busy", sts_hiz, 0);
            wsm_busy = 1'b0;
            @(negedge clk);
            check($sformatf("R3 level release op%0d", op), sts_drive_low, 0);
            check("R11 hiz complement idle", sts_hiz, 1);
        end
    endtask

    task automatic t_suspend();
        @(negedge clk);
        wsm_op = 2'd0;
        wsm_busy = 1'b1;
        @(negedge clk);
        wsm_suspended = 1'b1;
        @(negedge clk);
        check("R4 released while suspended", sts_drive_low, 0);
        @(negedge clk);
        check("R4 still released", sts_drive_low, 0);
        wsm_suspended = 1'b0;
        @(negedge clk);
        check("R4 low after resume", sts_drive_low, 1);
        wsm_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_erase_mode();
        int len;
        set_mode(2'd1);
        @(negedge clk);
        wsm_op = 2'd1;
        wsm_busy = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R7 no drive while busy in mode 1", sts_drive_low, 0);
        end
        wsm_busy = 1'b0;
        measure(len);
        check("R6 R7 chip erase pulse length", len, P);
        run_op(2'd0, 3);
        measure(len);
        check("R7 block erase pulse length", len, P);
        run_op(2'd2, 3);
        measure(len);
        check("R7 program masked in mode 1", len, 0);
    endtask

    task automatic t_prog_mode();
        int len;
        set_mode(2'd2);
        run_op(2'd0, 5);
        measure(len);
        check("R8 background erase masked", len, 0);
        run_op(2'd2, 2);
        measure(len);
        check("R8 program pulse length", len, P);
    endtask

    task automatic t_any_mode();
        int len;
        set_mode(2'd3);
        run_op(2'd1, 2);
        measure(len);
        check("R9 erase pulse in mode 3", len, P);
        run_op(2'd2, 2);
        measure(len);
        check("R9 program pulse in mode 3", len, P);
        run_op(2'd3, 2);
        measure(len);
        check("R9 lock config silent", len, 0);
    endtask

    task automatic t_retrigger();
        int len;
        run_op(2'd0, 2);           // mode 3 still selected
        @(negedge clk);
        check("R10 pulse started", sts_drive_low, 1);
        wsm_op = 2'd2;
        wsm_busy = 1'b1;
        len = 1;
        @(negedge clk);
        wsm_busy = 1'b0;
        while (sts_drive_low && len < 20) begin
            len++;
            @(negedge clk);
        end
        check("R10 retriggered length", len, P + 2);
    endtask

    task automatic t_cfg_clear();
        run_op(2'd0, 2);
        @(negedge clk);
        check("R5 pulse running before write", sts_drive_low, 1);
        cfg_wr = 1'b1;
        cfg_mode = 2'd1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R5 write cancels pulse", sts_drive_low, 0);
        set_mode(2'd0);
        @(negedge clk);
        wsm_busy = 1'b1;
        @(negedge clk);
        check("R5 back to level mode", sts_drive_low, 1);
        wsm_busy = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_level();
        t_suspend();
        t_erase_mode();
        t_prog_mode();
        t_any_mode();
        t_retrigger();
        t_cfg_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule